// File: doc/BRIEF.md
# Dual-Hash L2 Forwarding Table Search Engine

This block owns an on-chip L2 forwarding table and services one request at a time. Each request names a 48-bit station address and a 12-bit forwarding ID. The engine puts the ID above the address to form a 60-bit key. From that key it computes two 11-bit XOR-fold hashes. One is a plain fold. The other is the same fold with two of its slices rotated. Two configuration bits pick one of the two hashes for each half of the table.

The table is split into a lower and an upper half. Each half is a set of 4-entry buckets, so a key has eight candidate slots. The engine reads them from a synchronous RAM at one read per cycle, in a fixed order. It stops at the first slot that is empty or that already holds the same key. Entries flagged as next-hop entries are passed over. A lookup reports a hit, a free slot, or a full table. A write request runs the same search and stores the supplied entry, marked valid, into the chosen slot.

`BKT_IDX_W` sets how many hash bits index a bucket inside one half. With `BKT_IDX_W = 11` the table holds 16384 entries, and the upper-half bucket number equals the hash plus 2048. The default of 8 keeps the table small for elaboration.

Top module: `l2_dual_hash_lookup`

## Requirements
- R1: With hash-select bit b at 0, the bucket of half b is taken from fold0. The key is seed = {id, mac}, 60 bits. fold0 is the XOR of seed[59:55] (zero-extended to 11 bits), seed[54:44], seed[43:33], seed[32:22], seed[21:11] and seed[10:0]. The bucket is the low `BKT_IDX_W` bits of the fold.
- R2: With hash-select bit b at 1, half b uses fold1. fold1 is the same XOR, except that seed[43:33] is rotated left by 5 within 11 bits and seed[21:11] is rotated left by 6 within 11 bits. Bit 0 of `cfg_hash_sel` controls the lower half and bit 1 controls the upper half.
- R3: Slots 4 to 7 lie in the upper half of the table. For these slots the MSB of `res_addr` is 1. For slots 0 to 3 it is 0.
- R4: The table address of slot s is {s[2], bucket of half s[2], s[1:0]}.
- R5: Slots are examined in the order 0 to 7. The result is the first slot that qualifies, reported on `res_slot` and `res_addr`. `res_free` is set when that slot was empty.
- R6: A valid entry whose next-hop flag is set never qualifies, even when its key equals the request key.
- R7: A valid entry with the next-hop flag clear and a key equal to the request key qualifies and sets `res_hit`.
- R8: When none of the 8 slots qualifies, `res_full` is set and `res_hit` and `res_free` are clear.
- R9: A write request stores {req_nh, req_id, req_mac}, marked valid, into the selected slot. A later search for the same key finds it there.
- R10: A write request that finds no qualifying slot sets `res_err` together with `res_full` and leaves the table unchanged.
- R11: Let the start edge be the clock edge at which `start` is sampled high while idle. `done` is a one-cycle pulse s+2 edges after the start edge, where s is the selected slot, or 7 when the table is full. A write to a qualifying slot adds one more edge. `busy` is high from the start edge through the `done` cycle. A `start` that arrives while busy is ignored.
- R12: After reset the table is empty, and `busy`, `done` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request (accepted only when idle) |
| req_write | input | 1 | 1 = search then store, 0 = search only |
| req_mac | input | 48 | Station address of the request |
| req_id | input | 12 | Forwarding ID of the request |
| req_nh | input | 1 | Next-hop flag stored by a write |
| cfg_hash_sel | input | 2 | Per-half hash choice, 1 = rotated fold |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hit | output | 1 | Selected slot held the same key |
| res_free | output | 1 | Selected slot was empty |
| res_full | output | 1 | No slot qualified |
| res_err | output | 1 | Write refused because no slot qualified |
| res_slot | output | 3 | Selected candidate slot, 0 to 7 |
| res_addr | output | BKT_IDX_W+3 | Table address of the selected slot |

## Verification
The assertions check on every cycle that `done` never lasts two cycles and that each completion reports exactly one of hit, free or full. They also check that an error always comes with a full result, that a refused write never reaches the RAM, and that the address MSB agrees with the slot half.

Only the bench's scenarios can show the rest. These are the hash values for both folds, the search order, skipping of next-hop entries, overwriting of a matching key, and the exact completion latency for each slot. The bench checks them against a behavioural table model, for example by filling all eight slots of one key with next-hop entries until a write is refused.

// File: rtl/l2dh_pkg.sv
package l2dh_pkg;
    localparam int MAC_W  = 48;
    localparam int ID_W   = 12;
    localparam int SEED_W = ID_W + MAC_W;
    localparam int HASH_W = 11;
    localparam int SLOTS  = 8;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        logic             nh;
        logic [ID_W-1:0]  id;
        logic [MAC_W-1:0] mac;
    } l2_entry_t;

    localparam int ENTRY_W = $bits(l2_entry_t);

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WRITE, ST_FIN} state_t;

    // plain XOR fold of the 60-bit key
    function automatic logic [HASH_W-1:0] fold_plain(input logic [SEED_W-1:0] s);
        return {6'b0, s[59:55]} ^ s[54:44] ^ s[43:33] ^ s[32:22] ^ s[21:11] ^ s[10:0];
    endfunction

    // fold with two slices rotated inside 11 bits
    function automatic logic [HASH_W-1:0] fold_rot(input logic [SEED_W-1:0] s);
        logic [HASH_W-1:0] hi_rot;
        logic [HASH_W-1:0] lo_rot;
        hi_rot = {s[38:33], s[43:39]};   // rotate left by 5
        lo_rot = {s[15:11], s[21:16]};   // rotate left by 6
        return {6'b0, s[59:55]} ^ s[54:44] ^ hi_rot ^ s[32:22] ^ lo_rot ^ s[10:0];
    endfunction
endpackage

// File: rtl/l2dh_hash_unit.sv
module l2dh_hash_unit
    import l2dh_pkg::*;
#(
    parameter int BKT_IDX_W = 8
) (
    input  logic [SEED_W-1:0]                 seed,
    input  logic [1:0]                        sel,
    output logic [1:0][BKT_IDX_W-1:0]         bkt
);
    logic [HASH_W-1:0] h_plain;
    logic [HASH_W-1:0] h_rot;

    assign h_plain = fold_plain(seed);
    assign h_rot   = fold_rot(seed);

    for (genvar b = 0; b < 2; b++) begin : g_half
        logic [HASH_W-1:0] pick;
        assign pick   = sel[b] ? h_rot : h_plain;
        assign bkt[b] = pick[BKT_IDX_W-1:0];
        if (BKT_IDX_W < HASH_W) begin : g_trunc
            logic unused_hi;
            assign unused_hi = ^pick[HASH_W-1:BKT_IDX_W];
        end
    end
endmodule

// File: rtl/l2dh_slot_ram.sv
module l2dh_slot_ram
    import l2dh_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  l2_entry_t          wr_data,
    output logic               rd_vld,
    output l2_entry_t          rd_data
);
    localparam int DEPTH = 1 << AW;

    l2_entry_t          mem [DEPTH];
    logic [DEPTH-1:0]   vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= '0;
            rd_vld <= 1'b0;
        end else begin
            if (wr_en) begin
                vld[wr_addr] <= 1'b1;
            end
            if (rd_en) begin
                rd_vld <= vld[rd_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/l2_dual_hash_lookup.sv
module l2_dual_hash_lookup
    import l2dh_pkg::*;
#(
    parameter  int BKT_IDX_W = 8,
    localparam int ADDR_W    = BKT_IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_write,
    input  logic [47:0]       req_mac,
    input  logic [11:0]       req_id,
    input  logic              req_nh,
    input  logic [1:0]        cfg_hash_sel,
    output logic              busy,
    output logic              done,
    output logic              res_hit,
    output logic              res_free,
    output logic              res_full,
    output logic              res_err,
    output logic [2:0]        res_slot,
    output logic [ADDR_W-1:0] res_addr
);
    state_t                     state;
    l2_entry_t                  req_q;
    logic                       wr_q;
    logic [1:0]                 sel_q;
    logic [SLOT_W:0]            cnt;
    logic                       pend;
    logic [SLOT_W-1:0]          eval_slot;
    logic [1:0][BKT_IDX_W-1:0]  bkt;

    logic                       rd_en;
    logic [ADDR_W-1:0]          rd_addr;
    logic [ADDR_W-1:0]          eval_addr;
    logic                       rd_vld;
    l2_entry_t                  rd_data;
    logic                       ram_wr;
    logic                       key_eq;
    logic                       qual;

    l2dh_hash_unit #(.BKT_IDX_W(BKT_IDX_W)) hash_i (
        .seed (SEED_W'({req_q.id, req_q.mac})),
        .sel  (sel_q),
        .bkt  (bkt)
    );

    l2dh_slot_ram #(.AW(ADDR_W)) ram_i (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_en   (ram_wr),
        .wr_addr (res_addr),
        .wr_data (req_q),
        .rd_vld  (rd_vld),
        .rd_data (rd_data)
    );

    always_comb begin
        rd_en     = (state == ST_SCAN) && !cnt[SLOT_W];
        rd_addr   = {cnt[2], bkt[cnt[2]], cnt[1:0]};
        eval_addr = {eval_slot[2], bkt[eval_slot[2]], eval_slot[1:0]};
        key_eq    = (rd_data.id == req_q.id) && (rd_data.mac == req_q.mac);
        qual      = !rd_vld || (!rd_data.nh && key_eq);
        ram_wr    = (state == ST_WRITE);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_q     <= '0;
            wr_q      <= 1'b0;
            sel_q     <= '0;
            cnt       <= '0;
            pend      <= 1'b0;
            eval_slot <= '0;
            res_hit   <= 1'b0;
            res_free  <= 1'b0;
            res_full  <= 1'b0;
            res_err   <= 1'b0;
            res_slot  <= '0;
            res_addr  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= '{nh: req_nh, id: req_id, mac: req_mac};
                        wr_q  <= req_write;
                        sel_q <= cfg_hash_sel;
                        cnt   <= '0;
                        pend  <= 1'b0;
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (pend && qual) begin
                        res_slot <= eval_slot;
                        res_addr <= eval_addr;
                        res_hit  <= rd_vld;
                        res_free <= !rd_vld;
                        res_full <= 1'b0;
                        res_err  <= 1'b0;
                        pend     <= 1'b0;
                        state    <= wr_q ? ST_WRITE : ST_FIN;
                    end else if (pend && (eval_slot == SLOT_W'(SLOTS - 1))) begin
                        res_slot <= '0;
                        res_addr <= '0;
                        res_hit  <= 1'b0;
                        res_free <= 1'b0;
                        res_full <= 1'b1;
                        res_err  <= wr_q;
                        pend     <= 1'b0;
                        state    <= ST_FIN;
                    end else begin
                        pend      <= 1'b1;
                        eval_slot <= cnt[SLOT_W-1:0];
                        cnt       <= cnt + 1'b1;
                    end
                end
                ST_WRITE: state <= ST_FIN;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({res_hit, res_free, res_full}));

    assert_err_needs_full_R10: assert property (@(posedge clk) disable iff (rst)
        (done && res_err) |-> res_full);

    assert_no_write_on_full_R10: assert property (@(posedge clk) disable iff (rst)
        ram_wr |-> !res_full);

    assert_half_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !res_full) |-> (res_addr[ADDR_W-1] == res_slot[2]));
endmodule

// File: tb/l2_dual_hash_lookup_tb_top.sv
module l2_dual_hash_lookup_tb_top;
    localparam int BKT = 8;
    localparam int AW  = BKT + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic req_write = 1'b0;
    logic [47:0] req_mac = '0;
    logic [11:0] req_id = '0;
    logic req_nh = 1'b0;
    logic [1:0] cfg_hash_sel = '0;
    logic busy, done, res_hit, res_free, res_full, res_err;
    logic [2:0] res_slot;
    logic [AW-1:0] res_addr;

    int n_tests = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    l2_dual_hash_lookup #(.BKT_IDX_W(BKT)) dut_i (
        .clk(clk), .rst(rst), .start(start), .req_write(req_write),
        .req_mac(req_mac), .req_id(req_id), .req_nh(req_nh),
        .cfg_hash_sel(cfg_hash_sel), .busy(busy), .done(done),
        .res_hit(res_hit), .res_free(res_free), .res_full(res_full),
        .res_err(res_err), .res_slot(res_slot), .res_addr(res_addr)
    );

    // behavioural table model: address -> {nh, id, mac}
    bit [60:0] m_tab [int];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int mfold(input bit [59:0] s, input bit alt);
        longint sd = longint'(s);
        int a = int'((sd >> 55) & 'h1f);
        int b = int'((sd >> 44) & 'h7ff);
        int c = int'((sd >> 33) & 'h7ff);
        int d = int'((sd >> 22) & 'h7ff);
        int e = int'((sd >> 11) & 'h7ff);
        int f = int'(sd & 'h7ff);
        if (alt) begin
            c = ((c & 'h3f) << 5) | (c >> 6);
            e = ((e & 'h1f) << 6) | (e >> 5);
        end
        return a ^ b ^ c ^ d ^ e ^ f;
    endfunction

    function automatic int maddr(input bit [59:0] s, input bit [1:0] cfg, input int slot);
        int half = slot / 4;
        int h = mfold(s, cfg[half]) & ((1 << BKT) - 1);
        return (half << (BKT + 2)) | (h << 2) | (slot % 4);
    endfunction

    task automatic do_req(input bit wr, input bit [47:0] mac, input bit [11:0] id,
                          input bit nh, input bit [1:0] cfg, input bit poke,
                          input string tag);
        int sel = 8;
        bit e_hit = 0, e_free = 0;
        int n_lat;
        int e_addr = 0;
        bit t_ok = 1;
        for (int s = 0; s < 8; s++) begin
            int a = maddr({id, mac}, cfg, s);
            if (!m_tab.exists(a)) begin
                sel = s; e_free = 1; e_addr = a; break;
            end
            if (m_tab[a][60]) continue;                      // R6 skip next-hop
            if (m_tab[a][59:0] == {id, mac}) begin
                sel = s; e_hit = 1; e_addr = a; break;       // R7
            end
        end
        n_lat = (sel == 8) ? 9 : sel + 2 + ((wr) ? 1 : 0);
        @(negedge clk);
        start = 1; req_write = wr; req_mac = mac; req_id = id; req_nh = nh; cfg_hash_sel = cfg;
        for (int k = 0; k <= n_lat + 1; k++) begin
            @(negedge clk);
            start = 0;
            if (poke && k == 1) begin
                start = 1; req_mac = ~mac; req_id = ~id; req_write = 1;
            end
            if (busy !== (k <= n_lat) || done !== (k == n_lat)) t_ok = 0;
            if (k == n_lat) begin
                chk(res_full == (sel == 8), {tag, " R8"}, "full", res_full, sel == 8);
                chk(res_err == (wr && sel == 8), {tag, " R10"}, "err", res_err, wr && sel == 8);
                chk(res_hit == e_hit, {tag, " R7"}, "hit", res_hit, e_hit);
                chk(res_free == e_free, {tag, " R5"}, "free", res_free, e_free);
                if (sel < 8) begin
                    chk(res_slot == sel, {tag, " R5"}, "slot", res_slot, sel);
                    chk(res_addr == e_addr, {tag, " R4"}, "addr", res_addr, e_addr);
                end
            end
        end
        start = 0;
        chk(t_ok, {tag, " R11"}, "busy/done timing", 0, n_lat);
        if (wr && sel < 8) m_tab[e_addr] = {nh, id, mac};   // R9
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit [47:0] mac_a = 48'h0011_2233_4455;
        bit [11:0] id_a = 12'h00A;
        bit [47:0] mac_b = 48'h0A0B_0C0D_0E0F;
        bit [11:0] id_b = 12'h123;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !done, "R12", "busy/done", {busy, done}, 0);
        chk({res_hit, res_free, res_full, res_err, res_slot, res_addr} == '0, "R12",
            "results", res_addr, 0);
        // R1 plain fold on empty table, R2 rotated fold
        do_req(0, mac_a, id_a, 0, 2'b00, 0, "R1 empty-plain");
        do_req(0, mac_a, id_a, 0, 2'b01, 0, "R2 empty-rot");
        chk(mfold({id_a, mac_a}, 0) != mfold({id_a, mac_a}, 1), "R2", "folds differ",
            mfold({id_a, mac_a}, 1), mfold({id_a, mac_a}, 0));
        // R9 write then look up
        do_req(1, mac_a, id_a, 0, 2'b00, 0, "R9 write-a");
        do_req(0, mac_a, id_a, 0, 2'b00, 0, "R9 find-a");
        do_req(1, mac_a, id_a, 0, 2'b00, 0, "R7 overwrite-a");
        // R6/R3: fill all eight slots of key b with next-hop entries
        for (int i = 0; i < 8; i++) do_req(1, mac_b, id_b, 1, 2'b11, 0, "R6 nh-fill");
        do_req(1, mac_b, id_b, 1, 2'b11, 0, "R10 refused");
        do_req(0, mac_b, id_b, 0, 2'b11, 0, "R8 full-read");
        do_req(0, mac_b, id_b, 0, 2'b10, 0, "R3 mixed-cfg");
        // R11 start ignored while busy
        do_req(0, mac_a, id_a, 0, 2'b00, 1, "R11 poke");
        do_req(0, ~mac_a, ~id_a, 0, 2'b00, 0, "R11 poke-no-effect");
        // R5 assorted keys and configurations
        for (int i = 0; i < 12; i++) begin
            bit [47:0] m = 48'h5E00_0000_0000 + 48'(i) * 48'h0001_0203_0405;
            bit [11:0] v = 12'(i * 37);
            do_req(1, m, v, i[0], 2'(i), 0, "R5 mix-w");
            do_req(0, m, v, 0, 2'(i), 0, "R5 mix-r");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule